// File: doc/BRIEF.md
# Thread Fragility Classifier for Cache Fill Insertion

This block sits beside a shared cache that serves several hardware threads. It measures how hard each thread presses on the cache compared with the other threads. It then labels each thread as fragile, meaning it misses less than its share, or aggressive. On every fill it uses that label to choose how the new line is inserted. Each thread owns a signed pressure counter, and the counters are updated so that their total is always zero. A thread's standing is therefore judged only against the others. A miss adds to the missing thread's counter and takes from every other thread's counter.

The miss side takes a strobe and the thread number of the miss. The fill side takes a strobe and the thread number of the line being filled. The block returns one bimodal-or-normal decision for that fill in the same cycle. It also shows the fragile flag of every thread at all times. The per-set replacement state that acts on the decision lives outside this block.

Top module: `thread_ins_classifier`

## Requirements
- R1: Reset sets every pressure counter to zero. After reset no thread is fragile, and a fill for any thread 0..3 receives bimodal insertion.
- R2: An accepted miss from thread k (0..3) adds 3 to counter k and subtracts 1 from each of the other three counters. The change is visible on the outputs from the next cycle on, and the four counters always sum to zero.
- R3: The counters are 12-bit signed values in the range -2048..2047. If any counter would leave that range on a miss, none of the four counters change.
- R4: Bit i of `thread_fragile_o` is 1 exactly when counter i is below zero. A counter of exactly zero reads as aggressive (0).
- R5: When `fill_valid_i` is 1 and `fill_tid_i` is 0..3, `fill_bimodal_o` is 0 (normal insertion with the use bit set) if that thread is fragile. It is 1 (bimodal insertion) otherwise. The result is combinational in the same cycle.
- R6: When a miss and a fill arrive in the same cycle, the fill decision uses the counter values from before that miss is applied.
- R7: A miss whose `miss_tid_i` is 4..7, or any cycle with `miss_valid_i` at 0, leaves all counters unchanged.
- R8: `fill_bimodal_o` is 0 whenever `fill_valid_i` is 0. A valid fill with `fill_tid_i` 4..7 receives bimodal insertion (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid_i | input | 1 | A cache miss occurred this cycle |
| miss_tid_i | input | 3 | Thread number of the miss |
| fill_valid_i | input | 1 | A fill needs an insertion decision this cycle |
| fill_tid_i | input | 3 | Thread number of the fill |
| thread_fragile_o | output | 4 | Per-thread fragile flag, bit i for thread i |
| fill_bimodal_o | output | 1 | 1 = bimodal insertion, 0 = normal insertion |

## Verification
The bench drives one thread past the top of the counter range and keeps missing on it. A design that applies the update anyway would wrap that counter negative and flip its fragile flag, and a design that freezes only the overflowing counter would keep pulling the other threads down, so the later sign changes come at different cycles than the model predicts. A design that lets a miss change the fill decision in the same cycle gives the wrong mode on the first colliding fill. Thread numbers 4..7 must cause no drift in the counters, and four single misses, one per thread, must leave every counter at exactly zero. A design that treats zero as fragile would hand those fills normal insertion.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

  typedef enum logic {
    INS_NORMAL  = 1'b0,
    INS_BIMODAL = 1'b1
  } ins_mode_e;

  // Change applied to one counter when a miss lands; n_thr threads share the sum.
  function automatic int miss_step(input bit own, input int n_thr);
    return own ? (n_thr - 1) : -1;
  endfunction

  // True when v is representable as a w-bit two's complement value.
  function automatic bit fits_signed(input int v, input int w);
    int lo;
    int hi;
    lo = -(1 <<< (w - 1));
    hi = (1 <<< (w - 1)) - 1;
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/tfc_tid_decode.sv
module tfc_tid_decode #(
  parameter int N     = 4,
  parameter int TID_W = 3
) (
  input  logic             valid_i,
  input  logic [TID_W-1:0] tid_i,
  output logic [N-1:0]     onehot_o,
  output logic             hit_o
);

  logic in_range;

  assign in_range = (32'(tid_i) < N);
  assign hit_o    = valid_i && in_range;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign onehot_o[g] = hit_o && (32'(tid_i) == g);
  end

endmodule

// File: rtl/tfc_ctr_bank.sv
module tfc_ctr_bank #(
  parameter int N     = 4,
  parameter int CNT_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_i,
  input  logic [N-1:0]       sel_i,
  output logic [N*CNT_W-1:0] cnt_o,
  output logic               blocked_o,
  output logic               commit_o
);

  logic signed [CNT_W-1:0] cnt_q [N];
  logic signed [CNT_W-1:0] cnt_n [N];
  logic [N-1:0]            ovf;

  for (genvar g = 0; g < N; g++) begin : g_ctr
    logic ovf_g;
    int   sum_v;

    always_comb begin
      sum_v    = int'(cnt_q[g]) + tfc_pkg::miss_step(sel_i[g], N);
      ovf_g    = !tfc_pkg::fits_signed(sum_v, CNT_W);
      cnt_n[g] = sum_v[CNT_W-1:0];
    end

    assign ovf[g] = ovf_g;
    assign cnt_o[g*CNT_W +: CNT_W] = cnt_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
      end else if (commit_o) begin
        cnt_q[g] <= cnt_n[g];
      end
    end
  end

  assign blocked_o = upd_i && (|ovf);
  assign commit_o  = upd_i && !(|ovf);

endmodule

// File: rtl/tfc_mode_sel.sv
module tfc_mode_sel #(
  parameter int N     = 4,
  parameter int CNT_W = 12,
  parameter int TID_W = 3
) (
  input  logic [N*CNT_W-1:0] cnt_i,
  input  logic               fill_valid_i,
  input  logic [TID_W-1:0]   fill_tid_i,
  output logic [N-1:0]       fragile_o,
  output tfc_pkg::ins_mode_e mode_o
);

  logic [N-1:0] fill_sel;
  logic         fill_hit;
  logic         fill_fragile;

  for (genvar g = 0; g < N; g++) begin : g_sign
    assign fragile_o[g] = cnt_i[g*CNT_W + CNT_W - 1];
  end

  tfc_tid_decode #(.N(N), .TID_W(TID_W)) fill_dec_i (
    .valid_i  (fill_valid_i),
    .tid_i    (fill_tid_i),
    .onehot_o (fill_sel),
    .hit_o    (fill_hit)
  );

  assign fill_fragile = fill_hit && (|(fill_sel & fragile_o));

  always_comb begin
    if (!fill_valid_i) begin
      mode_o = tfc_pkg::INS_NORMAL;
    end else if (fill_fragile) begin
      mode_o = tfc_pkg::INS_NORMAL;
    end else begin
      mode_o = tfc_pkg::INS_BIMODAL;
    end
  end

endmodule

// File: rtl/thread_ins_classifier.sv
module thread_ins_classifier #(
  parameter int N     = 4,
  parameter int CNT_W = 12,
  parameter int TID_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid_i,
  input  logic [TID_W-1:0] miss_tid_i,
  input  logic             fill_valid_i,
  input  logic [TID_W-1:0] fill_tid_i,
  output logic [N-1:0]     thread_fragile_o,
  output logic             fill_bimodal_o
);

  logic [N-1:0]       miss_onehot;
  logic               miss_hit;
  logic               miss_commit;
  logic               miss_blocked;
  logic [N*CNT_W-1:0] cnt_flat;
  tfc_pkg::ins_mode_e fill_mode;

  tfc_tid_decode #(.N(N), .TID_W(TID_W)) miss_dec_i (
    .valid_i  (miss_valid_i),
    .tid_i    (miss_tid_i),
    .onehot_o (miss_onehot),
    .hit_o    (miss_hit)
  );

  tfc_ctr_bank #(.N(N), .CNT_W(CNT_W)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_i     (miss_hit),
    .sel_i     (miss_onehot),
    .cnt_o     (cnt_flat),
    .blocked_o (miss_blocked),
    .commit_o  (miss_commit)
  );

  tfc_mode_sel #(.N(N), .CNT_W(CNT_W), .TID_W(TID_W)) sel_i (
    .cnt_i        (cnt_flat),
    .fill_valid_i (fill_valid_i),
    .fill_tid_i   (fill_tid_i),
    .fragile_o    (thread_fragile_o),
    .mode_o       (fill_mode)
  );

  assign fill_bimodal_o = (fill_mode == tfc_pkg::INS_BIMODAL);

endmodule

// File: rtl/tfc_checker.sv
module tfc_checker #(
  parameter int N     = 4,
  parameter int CNT_W = 12,
  parameter int TID_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               miss_valid_i,
  input logic               fill_valid_i,
  input logic [TID_W-1:0]   fill_tid_i,
  input logic [N-1:0]       thread_fragile_o,
  input logic               fill_bimodal_o,
  input logic               miss_hit,
  input logic               miss_blocked,
  input logic [N*CNT_W-1:0] cnt_flat
);

  int cnt_sum;

  always_comb begin
    cnt_sum = 0;
    for (int i = 0; i < N; i++) begin
      cnt_sum = cnt_sum + int'($signed(cnt_flat[i*CNT_W +: CNT_W]));
    end
  end

  AST_SUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_sum == 0); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    miss_blocked |=> $stable(cnt_flat)); // R3

  AST_BAD_TID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid_i && !miss_hit) |=> $stable(cnt_flat)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_valid_i |=> $stable(cnt_flat)); // R7

  AST_FILL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid_i && (32'(fill_tid_i) < N)) |->
      (fill_bimodal_o == !(|(thread_fragile_o & (N'(1) << fill_tid_i))))); // R5

endmodule

bind thread_ins_classifier tfc_checker #(.N(N), .CNT_W(CNT_W), .TID_W(TID_W)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .miss_valid_i     (miss_valid_i),
  .fill_valid_i     (fill_valid_i),
  .fill_tid_i       (fill_tid_i),
  .thread_fragile_o (thread_fragile_o),
  .fill_bimodal_o   (fill_bimodal_o),
  .miss_hit         (miss_hit),
  .miss_blocked     (miss_blocked),
  .cnt_flat         (cnt_flat)
);

// File: tb/thread_ins_classifier_tb_top.sv
module thread_ins_classifier_tb_top;

  localparam int CLK_P   = 10;
  localparam int NT      = 4;
  localparam int CMAX    = 2047;
  localparam int CMIN    = -2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       miss_valid = 1'b0;
  logic [2:0] miss_tid = '0;
  logic       fill_valid = 1'b0;
  logic [2:0] fill_tid = '0;
  logic [3:0] fragile;
  logic       bimodal;

  int compared   = 0;
  int mismatched = 0;
  int model_cnt [NT];
  string phase = "R1";
  int seed = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  thread_ins_classifier dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .miss_valid_i     (miss_valid),
    .miss_tid_i       (miss_tid),
    .fill_valid_i     (fill_valid),
    .fill_tid_i       (fill_tid),
    .thread_fragile_o (fragile),
    .fill_bimodal_o   (bimodal)
  );

  function automatic logic [3:0] exp_fragile();
    logic [3:0] r;
    for (int i = 0; i < NT; i++) r[i] = (model_cnt[i] < 0);
    return r;
  endfunction

  function automatic logic exp_bimodal(input bit fv, input int ft);
    if (!fv) return 1'b0;
    if (ft >= NT) return 1'b1;
    return (model_cnt[ft] >= 0);
  endfunction

  // Model of one accepted miss: all-or-nothing update of the pressure values.
  task automatic model_miss(input int t);
    int trial [NT];
    bit ok;
    if (t >= NT) return;
    ok = 1'b1;
    for (int i = 0; i < NT; i++) begin
      trial[i] = (i == t) ? model_cnt[i] + 3 : model_cnt[i] - 1;
      if (trial[i] > CMAX || trial[i] < CMIN) ok = 1'b0;
    end
    if (ok) for (int i = 0; i < NT; i++) model_cnt[i] = trial[i];
  endtask

  task automatic compare_now(input bit fv, input int ft);
    logic [3:0] ef;
    logic eb;
    ef = exp_fragile();
    eb = exp_bimodal(fv, ft);
    compared++;
    if (fragile !== ef) begin
      mismatched++;
      $display("FAIL [%s/R4] fragile got %b expected %b", phase, fragile, ef);
    end
    compared++;
    if (bimodal !== eb) begin
      mismatched++;
      $display("FAIL [%s/R5] fill tid %0d bimodal got %b expected %b", phase, ft, bimodal, eb);
    end
  endtask

  task automatic step(input bit mv, input int mt, input bit fv, input int ft);
    @(negedge clk);
    miss_valid = mv;
    miss_tid   = 3'(mt);
    fill_valid = fv;
    fill_tid   = 3'(ft);
    #1;
    compare_now(fv, ft);
    @(posedge clk);
    if (mv) model_miss(mt);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    miss_valid = 1'b0;
    fill_valid = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NT; i++) model_cnt[i] = 0;
    rst_n = 1'b1;
  endtask

  function automatic int next_rand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fff;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL [watchdog] run did not finish, got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    do_reset();

    // R1: cleared state, every in-range fill is bimodal
    phase = "R1";
    for (int t = 0; t < NT; t++) step(0, 0, 1, t);

    // R2: single miss from thread 1 -> 3,-1,-1,-1 pattern
    phase = "R2";
    step(1, 1, 0, 0);
    for (int t = 0; t < NT; t++) step(0, 0, 1, t);
    step(1, 2, 1, 1);
    step(1, 2, 1, 2);
    step(0, 0, 1, 3);

    // R6: miss and fill collide; decision from pre-update values
    phase = "R6";
    do_reset();
    step(1, 0, 1, 1);
    step(1, 0, 1, 1);
    step(1, 1, 1, 1);
    step(1, 1, 1, 1);
    step(0, 0, 1, 0);

    // R4: one miss per thread leaves all counters at zero -> aggressive
    phase = "R4";
    do_reset();
    for (int t = 0; t < NT; t++) step(1, t, 0, 0);
    for (int t = 0; t < NT; t++) step(0, 0, 1, t);

    // R7: out-of-range miss ids and idle cycles change nothing
    phase = "R7";
    step(1, 2, 0, 0);
    for (int k = 0; k < 40; k++) step(1, 4 + (k % 4), 1, k % NT);
    for (int k = 0; k < 8; k++) step(0, k % NT, 1, k % NT);

    // R8: fill strobe low gives 0; out-of-range fill gives bimodal
    phase = "R8";
    for (int t = 0; t < 8; t++) step(0, 0, 0, t);
    for (int t = 4; t < 8; t++) step(0, 0, 1, t);

    // R3: drive thread 0 to the top of the range, then keep missing
    phase = "R3";
    do_reset();
    for (int k = 0; k < 700; k++) step(1, 0, 1, k % 8);
    for (int k = 0; k < 300; k++) step(1, 1, 1, k % NT);
    for (int k = 0; k < 200; k++) step(1, 2, 1, (k + 1) % NT);

    // R2: long mixed pattern, skewed so signs keep moving
    phase = "R2";
    do_reset();
    for (int k = 0; k < 3000; k++) begin
      int r;
      int mt;
      r  = next_rand();
      mt = ((r & 15) < 6) ? 3 : (r >> 4) & 7;
      step(((r >> 7) & 3) != 0, mt, (r >> 9) & 1, (r >> 10) & 7);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule